// File: doc/BRIEF.md
# Reference-Locked Burst Clock Generator

This block produces short bursts of clock pulses that are locked to the rising edges of a slow reference clock. It measures the reference period by counting ticks of a fast sampling clock, divides that count by a user multiplication factor, and snaps the quotient to the nearest of a bank of evenly spaced period stages. On each reference rising edge it then emits a fixed number of pulses at the chosen stage period, and it stays quiet until the next edge.

The measurement stands in for a time-to-digital converter. The stage bank stands in for a tapped delay line. The defaults give 64 stages, the fastest being 4 ticks long and each stage after it 2 ticks longer. A system clock taken from this block runs close to the multiplication factor times the reference frequency, and it never runs faster than the fastest stage allows. There is no data stream in this block, so every pin is a plain control or status pin.

Top module: `burst_clkgen`

## Requirements
- R1: While reset is held, and right after it is released, `busy`, `burst_clk` and `overrun` are 0 and `stage_code` is 0.
- R2: `ref_clk` passes through a two-flop synchronizer and an edge detector. The measured period M is the number of fast cycles between two consecutive synchronized rising edges. A burst can start only on a rising edge that has an earlier edge since reset.
- R3: The target is T = floor(M / `mult_nf`). Stage k has a period of S0 + k*STEP ticks, and stage 0 is the fastest. For T > S0, the chosen stage is k = floor((T - S0 + STEP/2) / STEP), so an exact tie between two stages goes to the slower one. With the defaults S0 = 4 and STEP = 2 this gives T = 50 → k = 23, and T = 43 → k = 20.
- R4: A target at or below the fastest period (T ≤ S0) selects stage 0. The output is never faster than stage 0.
- R5: A target beyond the slowest stage is clamped to stage 63 (period 130 ticks with the defaults).
- R6: A burst of length L at period P gives exactly L pulses on `burst_clk`. Each pulse is high for the first floor(P/2) ticks of its period. `busy` is high for exactly L*P consecutive cycles.
- R7: `stage_code` changes only when a burst starts, so it is constant for the whole of a burst.
- R8: A rising edge while `mult_nf` is 0 starts no burst and leaves `stage_code` unchanged.
- R9: A rising edge while `burst_len` is 0 starts no burst and leaves `stage_code` unchanged.
- R10: A rising edge that arrives while `busy` is high aborts the running burst and restarts with the new settings. It also sets `overrun`, which stays at 1 until reset.
- R11: `burst_clk` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast sampling clock; all state is clocked by it |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk | input | 1 | Reference clock, asynchronous to clk_fast |
| mult_nf | input | NF_W (8) | Frequency multiplication factor; 0 disables bursts |
| burst_len | input | LEN_W (4) | Number of pulses per burst; 0 disables bursts |
| stage_code | output | SW (6) | Stage used by the current or most recent burst |
| burst_clk | output | 1 | Burst clock output |
| busy | output | 1 | High while a burst is running |
| overrun | output | 1 | Sticky: a reference edge cut a burst short |

## Verification
The assertions assume a few things about the inputs. Reset is held across the first clock edges. `ref_clk` stays stable for several fast cycles around each transition. `mult_nf` and `burst_len` change only away from reference edges. Together these make the synchronized edge a clean single-cycle event. The stimulus drives every input on the falling edge of the fast clock. It places the reference edges on whole-tick intervals, and it changes the settings only at the instant a new reference edge is issued. Every burst except those in the deliberate overrun phase is chosen to end well before the next edge.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // Period, in fast ticks, of stage k.
  function automatic logic [31:0] stage_period(input logic [31:0] k,
                                               input logic [31:0] s0,
                                               input logic [31:0] step);
    return s0 + k * step;
  endfunction

  // Nearest stage for a target period; ties go to the slower stage.
  function automatic logic [31:0] nearest_stage(input logic [31:0] t,
                                                input logic [31:0] s0,
                                                input logic [31:0] step,
                                                input logic [31:0] nstage);
    logic [31:0] k;
    if (t <= s0) k = 32'd0;
    else begin
      k = (t - s0 + (step >> 1)) / step;
      if (k > nstage - 32'd1) k = nstage - 32'd1;
    end
    return k;
  endfunction
endpackage

// File: rtl/bcg_ref_sync.sv
module bcg_ref_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic rise
);
  logic s1_q, s2_q, d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      d_q  <= 1'b0;
    end else begin
      s1_q <= ref_in;
      s2_q <= s1_q;
      d_q  <= s2_q;
    end
  end

  assign rise = s2_q & ~d_q;
endmodule

// File: rtl/bcg_period_meter.sv
module bcg_period_meter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic [CNT_W-1:0] meas,
  output logic             primed
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;

  // Ticks since the last edge, counting the current cycle; saturates.
  assign meas   = (&cnt_q) ? cnt_q : cnt_q + ONE;
  assign primed = primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (rise) begin
      cnt_q    <= '0;
      primed_q <= 1'b1;
    end else if (!(&cnt_q)) begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/bcg_stage_enc.sv
module bcg_stage_enc #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NF_W   = 8,
  parameter int unsigned NSTAGE = 64,
  parameter int unsigned S0     = 4,
  parameter int unsigned STEP   = 2,
  parameter int unsigned SW     = 6,
  parameter int unsigned PER_W  = 8
) (
  input  logic [CNT_W-1:0] meas,
  input  logic [NF_W-1:0]  nf,
  output logic [SW-1:0]    stage,
  output logic [PER_W-1:0] per_ticks
);
  import bcg_pkg::*;

  logic [31:0] tgt, k, p;

  always_comb begin
    tgt = (nf == '0) ? 32'd0 : 32'(meas) / 32'(nf);
    k   = nearest_stage(tgt, 32'(S0), 32'(STEP), 32'(NSTAGE));
    p   = stage_period(k, 32'(S0), 32'(STEP));
  end

  assign stage     = SW'(k);
  assign per_ticks = PER_W'(p);
endmodule

// File: rtl/bcg_burst_engine.sv
module bcg_burst_engine #(
  parameter int unsigned PER_W = 8,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned SW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             launch,
  input  logic [SW-1:0]    stage_in,
  input  logic [PER_W-1:0] per_in,
  input  logic [LEN_W-1:0] len_in,
  output logic [SW-1:0]    stage_code,
  output logic             busy,
  output logic             burst_clk,
  output logic             overrun
);
  localparam logic [PER_W-1:0] P_ONE = {{(PER_W-1){1'b0}}, 1'b1};
  localparam logic [LEN_W-1:0] L_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [PER_W-1:0] per_q, phase_q;
  logic [LEN_W-1:0] len_q, pcnt_q;
  logic [SW-1:0]    stage_q;
  logic             busy_q, ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q   <= '0;
      phase_q <= '0;
      len_q   <= '0;
      pcnt_q  <= '0;
      stage_q <= '0;
      busy_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (rise) begin
      if (busy_q) ovr_q <= 1'b1;
      if (launch) begin
        busy_q  <= 1'b1;
        per_q   <= per_in;
        len_q   <= len_in;
        stage_q <= stage_in;
        phase_q <= '0;
        pcnt_q  <= '0;
      end else begin
        busy_q <= 1'b0;
      end
    end else if (busy_q) begin
      if (phase_q == per_q - P_ONE) begin
        phase_q <= '0;
        if (pcnt_q == len_q - L_ONE) busy_q <= 1'b0;
        else                         pcnt_q <= pcnt_q + L_ONE;
      end else begin
        phase_q <= phase_q + P_ONE;
      end
    end
  end

  assign stage_code = stage_q;
  assign busy       = busy_q;
  assign overrun    = ovr_q;
  assign burst_clk  = busy_q && (phase_q < (per_q >> 1));
endmodule

// File: rtl/burst_clkgen.sv
module burst_clkgen #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NF_W   = 8,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned NSTAGE = 64,
  parameter int unsigned S0     = 4,
  parameter int unsigned STEP   = 2
) (
  input  logic                       clk_fast,
  input  logic                       rst_n,
  input  logic                       ref_clk,
  input  logic [NF_W-1:0]            mult_nf,
  input  logic [LEN_W-1:0]           burst_len,
  output logic [$clog2(NSTAGE)-1:0]  stage_code,
  output logic                       burst_clk,
  output logic                       busy,
  output logic                       overrun
);
  localparam int unsigned SW    = $clog2(NSTAGE);
  localparam int unsigned PER_W = $clog2(S0 + (NSTAGE - 1) * STEP + 1);

  logic             rise_w, primed_w, launch_w;
  logic [CNT_W-1:0] meas_w;
  logic [SW-1:0]    stage_w;
  logic [PER_W-1:0] per_w;

  bcg_ref_sync u_sync (
    .clk(clk_fast), .rst_n(rst_n), .ref_in(ref_clk), .rise(rise_w)
  );

  bcg_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk_fast), .rst_n(rst_n), .rise(rise_w),
    .meas(meas_w), .primed(primed_w)
  );

  bcg_stage_enc #(
    .CNT_W(CNT_W), .NF_W(NF_W), .NSTAGE(NSTAGE), .S0(S0), .STEP(STEP),
    .SW(SW), .PER_W(PER_W)
  ) u_enc (
    .meas(meas_w), .nf(mult_nf), .stage(stage_w), .per_ticks(per_w)
  );

  assign launch_w = rise_w && primed_w && (mult_nf != '0) && (burst_len != '0);

  bcg_burst_engine #(.PER_W(PER_W), .LEN_W(LEN_W), .SW(SW)) u_eng (
    .clk(clk_fast), .rst_n(rst_n), .rise(rise_w), .launch(launch_w),
    .stage_in(stage_w), .per_in(per_w), .len_in(burst_len),
    .stage_code(stage_code), .busy(busy), .burst_clk(burst_clk),
    .overrun(overrun)
  );
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
  parameter int unsigned SW   = 6,
  parameter int unsigned NF_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rise,
  input logic [NF_W-1:0] nf,
  input logic [SW-1:0]   stage_code,
  input logic            busy,
  input logic            burst_clk,
  input logic            overrun
);
  // R11
  clk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_clk |-> busy);

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(stage_code));

  // R8
  nf_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && nf == '0) |=> !busy);

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rise && busy));
endmodule

bind burst_clkgen bcg_chk #(.SW(SW), .NF_W(NF_W)) u_chk (
  .clk(clk_fast), .rst_n(rst_n), .rise(rise_w), .nf(mult_nf),
  .stage_code(stage_code), .busy(busy), .burst_clk(burst_clk),
  .overrun(overrun)
);

// File: tb/sim_burst_clkgen.sv
module sim_burst_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic [7:0] mult_nf = 8'd0;
  logic [3:0] burst_len = 4'd0;
  logic [5:0] stage_code;
  logic       burst_clk, busy, overrun;

  int checks = 0, fails = 0;
  int q_stage[$], q_cyc[$], q_pul[$];
  int prev_t = 0;
  int last_stage = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  burst_clkgen u0 (
    .clk_fast(clk), .rst_n(rst_n), .ref_clk(ref_clk), .mult_nf(mult_nf),
    .burst_len(burst_len), .stage_code(stage_code), .burst_clk(burst_clk),
    .busy(busy), .overrun(overrun)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected stage from the requirements (S0=4, STEP=2, 64 stages).
  function automatic int exp_stage(input int m, input int nf);
    int t, k;
    t = m / nf;
    if (t <= 4) k = 0;
    else begin
      k = (t - 4 + 1) / 2;
      if (k > 63) k = 63;
    end
    return k;
  endfunction

  // Driver: n reference edges spaced t ticks apart; pushes expected bursts.
  task automatic drive(input int t, input int n, input int nf, input int len);
    for (int i = 0; i < n; i++) begin
      if (i == 0) begin
        mult_nf   = 8'(nf);
        burst_len = 4'(len);
      end
      ref_clk = 1'b1;
      if (prev_t > 0 && nf != 0 && len != 0) begin
        int k;
        k = exp_stage(prev_t, nf);
        q_stage.push_back(k);
        q_cyc.push_back(len * (4 + 2 * k));
        q_pul.push_back(len);
        last_stage = k;
      end
      prev_t = t;
      repeat (t / 2) @(negedge clk);
      ref_clk = 1'b0;
      repeat (t - t / 2) @(negedge clk);
    end
  endtask

  // Monitor: measures each burst and compares with the queue front.
  int  m_stage, m_cyc, m_pul;
  bit  p_busy = 1'b0, p_clk = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (busy && !p_busy) begin
        m_stage = int'(stage_code);
        m_cyc = 0;
        m_pul = 0;
      end
      if (busy) begin
        m_cyc++;
        if (burst_clk && !p_clk) m_pul++;
      end
      if (!busy && burst_clk) check("R11 clk while idle", 1, 0);
      if (!busy && p_busy) begin
        if (q_stage.size() == 0) check("R8/R9 unexpected burst", 1, 0);
        else begin
          check("R3 stage", m_stage, q_stage.pop_front());
          check("R6 busy length", m_cyc, q_cyc.pop_front());
          check("R6 pulse count", m_pul, q_pul.pop_front());
        end
      end
    end
    p_busy = busy;
    p_clk  = burst_clk;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 clk in reset", burst_clk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 overrun", overrun, 0);
    check("R1 stage", stage_code, 0);
    mon_on = 1'b1;

    // R2 first edge has no history; R3 worked case T=200/4=50 -> k23
    drive(200, 4, 4, 3);
    drive(200, 3, 5, 4);                  // T=40 -> k18
    // R3 tie: 215/5=43 -> k20 (slower of 42/44)
    drive(215, 3, 5, 3);
    // R4 fast clamp: 100/50=2 -> k0
    drive(100, 3, 50, 5);
    // R5 slow clamp: 600/1 -> k63
    drive(600, 3, 1, 4);
    check("R5 clamp stage", stage_code, 63);
    check("R6 queue drained", q_stage.size(), 0);

    // R8 mult 0: no bursts, stage unchanged
    drive(200, 3, 0, 3);
    check("R8 stage unchanged", stage_code, last_stage);
    check("R8 no bursts", q_stage.size(), 0);
    // R9 length 0: no bursts, stage unchanged
    drive(200, 3, 4, 0);
    check("R9 stage unchanged", stage_code, last_stage);
    check("R9 no bursts", q_stage.size(), 0);
    drive(200, 2, 4, 2);
    check("R3 resumed stage", stage_code, 23);
    check("R10 no overrun yet", overrun, 0);
    check("R6 queue drained 2", q_stage.size(), 0);

    // R10 overrun: bursts longer than reference period
    mon_on = 1'b0;
    drive(100, 3, 1, 2);
    check("R10 overrun set", overrun, 1);
    check("R10 busy restarted", busy, 1);
    drive(600, 2, 1, 1);
    repeat (300) @(negedge clk);
    check("R10 overrun sticky", overrun, 1);
    check("R6 idle after burst", busy, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule